// File: doc/BRIEF.md
# Wearable Power Mode Controller

This block selects the operating mode of a small battery-powered wearable and drives the enables of its switched power domains. It moves between six modes: storage (shipping), idle while not worn, a short wear-detect probe, a timed measurement window, a radio sync burst, and charging. The always-on domain (timebase, wake logic, logging) is not gated here. Outside this block, the radio stack, the analog charger and the undervoltage comparator produce the status inputs that the controller reads.

A second function watches the battery comparator outputs. Each debounced low-battery assertion raises a degrade level by one, up to four. The comparator's upper threshold must be seen before another assertion can count, so the flag has hysteresis. The level falls back to zero only after the battery-ok indication has held for a programmable time. Downstream logic uses levels 1 to 3 to shorten LED pulses, slow the sync rate and serialise bursts. Level 4 is acted on here: it stops all high-sensitivity capture. Every reset release and every debounced brownout produces a one-cycle event record. The record holds a reason code and the LED, radio and charge activity seen at that instant.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_code is 0 (shipping), every domain enable is 0 and degrade_lvl is 0. At the first clock edge after reset release, evt_stb pulses for one cycle with evt_reason 1 (reset) and evt_flags {chg,rf,led} = {chg_active,0,0}.
- R2: In shipping mode only dock_attach or long_press cause a change, and the next mode is idle (code 1). rtc_tick, contact_valid/contact_ok and chg_active have no effect on the mode while in shipping mode.
- R3: In idle (code 1), every PROBE_DIV-th rtc_tick pulse moves the block to wear-detect (code 2). en_contact is 1 in wear-detect and in no other mode.
- R4: Wear-detect lasts at most PROBE_LEN cycles and then returns to idle. contact_valid with contact_ok=0 returns to idle. contact_valid with contact_ok=1 enters measure (code 3) and latches meas_sel (bit 0 selects the optical channel, bit 1 the skin-conductance channel).
- R5: In measure, en_ppg equals latched bit 0 and en_eda equals latched bit 1, and en_radio is 0. Measure lasts MEAS_WIN cycles, or ends earlier on meas_done, and then moves to sync (code 4). Sync drives en_radio=1 and returns to idle on sync_done.
- R6: chg_active in any mode other than shipping enters charge (code 5). In charge, en_ppg and en_eda are 0 and en_radio = sync_req AND rails_stable. Charge returns to idle when chg_active falls.
- R7: batt_low high on DEB consecutive edges raises degrade_lvl by one, saturating at 4. batt_low pulses shorter than DEB edges have no effect. After a counted assertion, further batt_low cycles do not count until batt_ok has been seen.
- R8: degrade_lvl returns to 0 at the (hold_cfg+1)-th consecutive edge with batt_ok high. A cycle with batt_ok low restarts the count.
- R9: At degrade_lvl 4, a confirmed contact returns to idle instead of entering measure, and en_ppg and en_eda stay 0.
- R10: Each debounced low-battery assertion pulses evt_stb with evt_reason 2 (brownout) and evt_flags = {chg_active, en_radio, en_ppg} as sampled at that edge.
- R11: mode_code is the binary index of the active mode (0 shipping, 1 idle, 2 wear-detect, 3 measure, 4 sync, 5 charge), and en_radio is never 1 together with en_ppg or en_eda.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| rtc_tick | input | 1 | Periodic timebase pulse |
| dock_attach | input | 1 | Dock presence detected |
| long_press | input | 1 | User long-press detected |
| contact_valid | input | 1 | Contact discriminator result is ready |
| contact_ok | input | 1 | Contact discriminator result (1 = worn) |
| meas_sel | input | 2 | Requested channels: bit 0 optical, bit 1 skin conductance |
| meas_done | input | 1 | Measurement sequencer finished |
| sync_done | input | 1 | Sync sequencer finished |
| sync_req | input | 1 | Sync burst requested while charging |
| chg_active | input | 1 | Charger reports charging |
| rails_stable | input | 1 | Switched rails are reported good |
| batt_low | input | 1 | Comparator lower-threshold output |
| batt_ok | input | 1 | Comparator upper-threshold output |
| hold_cfg | input | HOLD_W | Recovery hold time in cycles |
| en_contact | output | 1 | Contact discriminator domain enable |
| en_ppg | output | 1 | Optical LED and front-end domain enable |
| en_eda | output | 1 | Skin-conductance front-end domain enable |
| en_radio | output | 1 | Radio domain enable |
| mode_code | output | 3 | Binary mode code |
| degrade_lvl | output | 3 | Degrade level 0 to 4 |
| evt_stb | output | 1 | Event record valid pulse |
| evt_reason | output | 2 | Event reason: 1 reset, 2 brownout |
| evt_flags | output | 3 | {charge, radio, LED} activity at the event |

## Verification
The assertions take for granted that batt_low and batt_ok are never high together, because a comparator with hysteresis cannot report both thresholds at once. They also take for granted that the inputs are already synchronous to clk. The bench drives every input one nanosecond after a rising edge and changes batt_low and batt_ok only in a mutually exclusive way. The done strobes, dock and press inputs are held for whole cycles only. As a result, each transition the assertions reason about sees a stable value at exactly one edge.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int NMODES  = 6;
  localparam int I_SHIP  = 0;
  localparam int I_IDLE  = 1;
  localparam int I_WEAR  = 2;
  localparam int I_MEAS  = 3;
  localparam int I_SYNC  = 4;
  localparam int I_CHG   = 5;
  localparam int DEG_MAX = 4;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_RESET = 2'd1,
    EVT_BROWN = 2'd2
  } evt_e;

  // one-hot vector with a single bit at position idx
  function automatic logic [NMODES-1:0] mode_oh(input int idx);
    return NMODES'(1) << idx;
  endfunction

  // binary index of the set bit of a one-hot mode vector
  function automatic logic [2:0] oh_to_code(input logic [NMODES-1:0] oh);
    logic [2:0] c;
    c = 3'd0;
    for (int i = 0; i < NMODES; i++)
      if (oh[i]) c = 3'(i);
    return c;
  endfunction

  // one rung up the degrade ladder, saturating at the top rung
  function automatic logic [2:0] deg_up(input logic [2:0] cur);
    return (cur >= 3'(DEG_MAX)) ? 3'(DEG_MAX) : cur + 3'd1;
  endfunction
endpackage

// File: rtl/pmc_degrade.sv
`timescale 1ns/1ps
module pmc_degrade
  import pmc_pkg::*;
#(
  parameter int DEB    = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              batt_low,
  input  logic              batt_ok,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic [2:0]        lvl,
  output logic              step_pulse
);
  localparam int DBW = (DEB > 1) ? $clog2(DEB) : 1;

  logic           lowflag;
  logic [DBW-1:0] lo_cnt;
  logic [HOLD_W-1:0] ok_cnt;
  logic           clr_hit;

  assign step_pulse = !lowflag && batt_low && (lo_cnt == DBW'(DEB - 1));
  assign clr_hit    = batt_ok && (ok_cnt >= hold_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowflag <= 1'b0;
      lo_cnt  <= '0;
      ok_cnt  <= '0;
      lvl     <= 3'd0;
    end else begin
      if (step_pulse) begin
        lowflag <= 1'b1;
        lo_cnt  <= '0;
      end else if (!lowflag) begin
        lo_cnt <= batt_low ? lo_cnt + DBW'(1) : '0;
      end else if (batt_ok) begin
        lowflag <= 1'b0;
      end

      if (!batt_ok)               ok_cnt <= '0;
      else if (ok_cnt < hold_cfg) ok_cnt <= ok_cnt + HOLD_W'(1);

      if (step_pulse)   lvl <= deg_up(lvl);
      else if (clr_hit) lvl <= 3'd0;
    end
  end

  a_r7_one_rung: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl == 3'd0) || (lvl == $past(lvl)) || (lvl == $past(lvl) + 3'd1));
  a_r7_rearm_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (lowflag && !batt_ok) |=> lowflag && !step_pulse);
  a_r8_no_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != 3'd0 && !batt_ok) |=> lvl != 3'd0);
  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= 3'(DEG_MAX));
endmodule

// File: rtl/pmc_mode_fsm.sv
`timescale 1ns/1ps
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int PROBE_DIV = 8,
  parameter int PROBE_LEN = 16,
  parameter int MEAS_WIN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic              dock_attach,
  input  logic              long_press,
  input  logic              contact_valid,
  input  logic              contact_ok,
  input  logic [1:0]        meas_sel,
  input  logic              meas_done,
  input  logic              sync_done,
  input  logic              chg_active,
  input  logic              deg_stop,
  output logic [NMODES-1:0] st,
  output logic [1:0]        sel_q
);
  localparam int TKW  = (PROBE_DIV > 1) ? $clog2(PROBE_DIV) : 1;
  localparam int MAXW = (PROBE_LEN > MEAS_WIN) ? PROBE_LEN : MEAS_WIN;
  localparam int TMW  = $clog2(MAXW + 1);

  logic [NMODES-1:0] nxt;
  logic [TKW-1:0]    tick_cnt;
  logic [TMW-1:0]    tmr;
  logic              probe_due, wear_expire, meas_expire;

  assign probe_due   = rtc_tick && (tick_cnt == TKW'(PROBE_DIV - 1));
  assign wear_expire = (tmr == TMW'(PROBE_LEN - 1));
  assign meas_expire = (tmr == TMW'(MEAS_WIN - 1));

  always_comb begin
    nxt = st;
    if (st[I_SHIP]) begin
      if (dock_attach || long_press) nxt = mode_oh(I_IDLE);
    end else if (st[I_CHG]) begin
      if (!chg_active) nxt = mode_oh(I_IDLE);
    end else if (chg_active) begin
      nxt = mode_oh(I_CHG);
    end else if (st[I_IDLE]) begin
      if (probe_due) nxt = mode_oh(I_WEAR);
    end else if (st[I_WEAR]) begin
      if (contact_valid)
        nxt = (contact_ok && !deg_stop) ? mode_oh(I_MEAS) : mode_oh(I_IDLE);
      else if (wear_expire)
        nxt = mode_oh(I_IDLE);
    end else if (st[I_MEAS]) begin
      if (meas_done || deg_stop || meas_expire) nxt = mode_oh(I_SYNC);
    end else if (st[I_SYNC]) begin
      if (sync_done) nxt = mode_oh(I_IDLE);
    end else begin
      nxt = mode_oh(I_SHIP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= mode_oh(I_SHIP);
      sel_q    <= 2'b00;
      tick_cnt <= '0;
      tmr      <= '0;
    end else begin
      st <= nxt;
      if (st[I_WEAR] && nxt[I_MEAS]) sel_q <= meas_sel;
      if (!st[I_IDLE])    tick_cnt <= '0;
      else if (rtc_tick)  tick_cnt <= probe_due ? '0 : tick_cnt + TKW'(1);
      if (nxt != st)      tmr <= '0;
      else if (tmr != '1) tmr <= tmr + TMW'(1);
    end
  end

  a_r2_ship_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st[I_SHIP] && !dock_attach && !long_press) |=> st[I_SHIP]);
  a_r2_ship_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st[I_SHIP] && (dock_attach || long_press)) |=> st[I_IDLE]);
  a_r4_wear_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st[I_WEAR] && wear_expire) |=> !st[I_WEAR]);
  a_r5_meas_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st[I_MEAS] && meas_expire) |=> !st[I_MEAS]);
  a_r11_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(st));
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int PROBE_DIV = 8,
  parameter int PROBE_LEN = 16,
  parameter int MEAS_WIN  = 64,
  parameter int DEB       = 4,
  parameter int HOLD_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic              dock_attach,
  input  logic              long_press,
  input  logic              contact_valid,
  input  logic              contact_ok,
  input  logic [1:0]        meas_sel,
  input  logic              meas_done,
  input  logic              sync_done,
  input  logic              sync_req,
  input  logic              chg_active,
  input  logic              rails_stable,
  input  logic              batt_low,
  input  logic              batt_ok,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              en_contact,
  output logic              en_ppg,
  output logic              en_eda,
  output logic              en_radio,
  output logic [2:0]        mode_code,
  output logic [2:0]        degrade_lvl,
  output logic              evt_stb,
  output logic [1:0]        evt_reason,
  output logic [2:0]        evt_flags
);
  logic [NMODES-1:0] st;
  logic [1:0]        sel_q;
  logic              brown_step;
  logic              deg_stop;
  logic              rst_pend;

  assign deg_stop = (degrade_lvl == 3'(DEG_MAX));

  pmc_degrade #(.DEB(DEB), .HOLD_W(HOLD_W)) u_deg (
    .clk(clk), .rst_n(rst_n), .batt_low(batt_low), .batt_ok(batt_ok),
    .hold_cfg(hold_cfg), .lvl(degrade_lvl), .step_pulse(brown_step)
  );

  pmc_mode_fsm #(.PROBE_DIV(PROBE_DIV), .PROBE_LEN(PROBE_LEN), .MEAS_WIN(MEAS_WIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .dock_attach(dock_attach),
    .long_press(long_press), .contact_valid(contact_valid), .contact_ok(contact_ok),
    .meas_sel(meas_sel), .meas_done(meas_done), .sync_done(sync_done),
    .chg_active(chg_active), .deg_stop(deg_stop), .st(st), .sel_q(sel_q)
  );

  assign mode_code  = oh_to_code(st);
  assign en_contact = st[I_WEAR];
  assign en_ppg     = st[I_MEAS] && sel_q[0] && !deg_stop;
  assign en_eda     = st[I_MEAS] && sel_q[1] && !deg_stop;
  assign en_radio   = st[I_SYNC] || (st[I_CHG] && sync_req && rails_stable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend   <= 1'b1;
      evt_stb    <= 1'b0;
      evt_reason <= EVT_NONE;
      evt_flags  <= 3'b000;
    end else begin
      rst_pend <= 1'b0;
      evt_stb  <= rst_pend || brown_step;
      if (rst_pend) begin
        evt_reason <= EVT_RESET;
        evt_flags  <= {chg_active, 1'b0, 1'b0};
      end else if (brown_step) begin
        evt_reason <= EVT_BROWN;
        evt_flags  <= {chg_active, en_radio, en_ppg};
      end
    end
  end

  a_r6_charge_blocks_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'(I_CHG)) |-> (!en_ppg && !en_eda));
  a_r11_no_radio_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    en_radio |-> !(en_ppg || en_eda));
  a_r9_top_rung_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (degrade_lvl == 3'(DEG_MAX)) |-> (!en_ppg && !en_eda));
  a_r3_probe_only_in_wear: assert property (@(posedge clk) disable iff (!rst_n)
    en_contact |-> (mode_code == 3'(I_WEAR)));
  a_r10_brownout_logged: assert property (@(posedge clk) disable iff (!rst_n)
    brown_step |=> (evt_stb && evt_reason == EVT_BROWN));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int PD = 2, PL = 4, MW = 5, DB = 3, HW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rtc_tick = 0, dock_attach = 0, long_press = 0, contact_valid = 0, contact_ok = 0;
  logic [1:0] meas_sel = 2'b00;
  logic meas_done = 0, sync_done = 0, sync_req = 0, chg_active = 0, rails_stable = 0;
  logic batt_low = 0, batt_ok = 0;
  logic [HW-1:0] hold_cfg = 4'd6;
  logic en_contact, en_ppg, en_eda, en_radio, evt_stb;
  logic [2:0] mode_code, degrade_lvl, evt_flags;
  logic [1:0] evt_reason;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.PROBE_DIV(PD), .PROBE_LEN(PL), .MEAS_WIN(MW), .DEB(DB), .HOLD_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .dock_attach(dock_attach),
    .long_press(long_press), .contact_valid(contact_valid), .contact_ok(contact_ok),
    .meas_sel(meas_sel), .meas_done(meas_done), .sync_done(sync_done), .sync_req(sync_req),
    .chg_active(chg_active), .rails_stable(rails_stable), .batt_low(batt_low),
    .batt_ok(batt_ok), .hold_cfg(hold_cfg), .en_contact(en_contact), .en_ppg(en_ppg),
    .en_eda(en_eda), .en_radio(en_radio), .mode_code(mode_code), .degrade_lvl(degrade_lvl),
    .evt_stb(evt_stb), .evt_reason(evt_reason), .evt_flags(evt_flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    rtc_tick = 1; step(); rtc_tick = 0;
  endtask

  task automatic go_wear();
    for (int i = 0; i < PD; i++) tick();
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R1 reset state and reset event
    chk("R1 mode", mode_code, 0);
    chk("R1 enables", {en_contact, en_ppg, en_eda, en_radio}, 0);
    chk("R1 degrade", degrade_lvl, 0);
    chk("R1 no event yet", evt_stb, 0);
    step();
    chk("R1 evt_stb", evt_stb, 1);
    chk("R1 reason", evt_reason, 1);
    chk("R1 flags", evt_flags, 0);
    step();
    chk("R1 evt one cycle", evt_stb, 0);

    // R2 shipping ignores every combination of other wake sources
    for (int m = 1; m < 8; m++) begin
      rtc_tick = m[0]; contact_valid = m[1]; contact_ok = m[1]; chg_active = m[2];
      step();
      chk("R2 ship ignores", mode_code, 0);
    end
    rtc_tick = 0; contact_valid = 0; contact_ok = 0; chg_active = 0;
    dock_attach = 1; step(); dock_attach = 0;
    chk("R2 dock exits to idle", mode_code, 1);

    // R3 probe every PD ticks
    tick();
    chk("R3 one tick stays idle", mode_code, 1);
    chk("R3 no probe in idle", en_contact, 0);
    tick();
    chk("R3 probe entered", mode_code, 2);
    chk("R3 contact enabled", en_contact, 1);

    // R4 timeout length
    n = 0;
    while (mode_code == 2 && n < 20) begin n++; step(); end
    chk("R4 wear length", n, PL);
    chk("R4 timeout to idle", mode_code, 1);
    go_wear();
    contact_valid = 1; contact_ok = 0; step(); contact_valid = 0;
    chk("R4 no contact to idle", mode_code, 1);

    // R4/R5 sweep over channel selections
    for (int s = 0; s < 4; s++) begin
      go_wear();
      contact_valid = 1; contact_ok = 1; meas_sel = 2'(s); step();
      contact_valid = 0; meas_sel = 2'(3 - s);
      chk("R4 contact to measure", mode_code, 3);
      chk("R5 ppg enable", en_ppg, s & 1);
      chk("R5 eda enable", en_eda, (s >> 1) & 1);
      chk("R5 radio off in measure", en_radio, 0);
      n = 0;
      while (mode_code == 3 && n < 20) begin n++; step(); end
      chk("R5 window length", n, MW);
      chk("R5 to sync", mode_code, 4);
      chk("R5 radio in sync", en_radio, 1);
      sync_done = 1; step(); sync_done = 0;
      chk("R5 sync to idle", mode_code, 1);
    end
    go_wear();
    contact_valid = 1; contact_ok = 1; meas_sel = 2'd3; step(); contact_valid = 0;
    step();
    meas_done = 1; step(); meas_done = 0;
    chk("R5 early done", mode_code, 4);
    sync_done = 1; step(); sync_done = 0;

    // R6 charge
    chg_active = 1; step();
    chk("R6 idle to charge", mode_code, 5);
    chk("R6 capture blocked", {en_ppg, en_eda}, 0);
    sync_req = 1; rails_stable = 0; #1;
    chk("R6 radio needs rails", en_radio, 0);
    rails_stable = 1; #1;
    chk("R6 radio with rails", en_radio, 1);
    sync_req = 0; #1;
    chk("R6 radio needs request", en_radio, 0);
    tick(); tick();
    chk("R6 ticks ignored in charge", mode_code, 5);
    chg_active = 0; step();
    chk("R6 charge exit", mode_code, 1);
    go_wear();
    contact_valid = 1; contact_ok = 1; meas_sel = 2'd3; step(); contact_valid = 0;
    chg_active = 1; step();
    chk("R6 measure to charge", mode_code, 5);
    chk("R6 capture off", {en_ppg, en_eda}, 0);
    chg_active = 0; rails_stable = 0; step();

    // R7/R10 first rung taken during an optical measurement
    go_wear();
    contact_valid = 1; contact_ok = 1; meas_sel = 2'd1; batt_low = 1; step();
    contact_valid = 0;
    step();
    chk("R7 not yet", degrade_lvl, 0);
    step();
    chk("R7 first rung", degrade_lvl, 1);
    chk("R10 evt", evt_stb, 1);
    chk("R10 reason", evt_reason, 2);
    chk("R10 flags led", evt_flags, 1);
    step(); step(); step();
    chk("R7 held low not recounted", degrade_lvl, 1);
    while (mode_code != 4) step();
    sync_done = 1; step(); sync_done = 0;
    batt_low = 0; batt_ok = 1; step(); batt_ok = 0;
    // short pulses do not count
    batt_low = 1; step(); step(); batt_low = 0; step();
    batt_low = 1; step(); step(); batt_low = 0; step();
    chk("R7 glitches ignored", degrade_lvl, 1);
    for (int k = 2; k <= 5; k++) begin
      batt_low = 1;
      for (int j = 0; j < DB; j++) step();
      chk("R7 rung", degrade_lvl, (k > 4) ? 4 : k);
      chk("R10 evt each", evt_stb, 1);
      chk("R10 flags idle", evt_flags, 0);
      batt_low = 0; batt_ok = 1; step(); batt_ok = 0;
    end

    // R9 top rung stops capture
    go_wear();
    contact_valid = 1; contact_ok = 1; meas_sel = 2'd3; step(); contact_valid = 0;
    chk("R9 no measure", mode_code, 1);
    chk("R9 capture off", {en_ppg, en_eda}, 0);

    // R8 hold with a gap, then a sweep of hold values
    hold_cfg = 4'd6;
    batt_ok = 1; repeat (4) step(); batt_ok = 0; step();
    batt_ok = 1; repeat (6) step();
    chk("R8 not yet cleared", degrade_lvl, 4);
    step();
    chk("R8 cleared", degrade_lvl, 0);
    batt_ok = 0;
    for (int h = 0; h < 7; h += 3) begin
      hold_cfg = 4'(h);
      batt_low = 1; repeat (DB) step(); batt_low = 0;
      chk("R7 rung before hold", degrade_lvl, 1);
      batt_ok = 1; n = 0;
      while (degrade_lvl != 0 && n < 20) begin n++; step(); end
      batt_ok = 0;
      chk("R8 hold length", n, h + 1);
    end

    // R1/R2 reset while charging, then exit by long press
    chg_active = 1;
    do_reset();
    step();
    chk("R1 reset reason", evt_reason, 1);
    chk("R1 reset flags", evt_flags, 4);
    chk("R2 charger ignored in ship", mode_code, 0);
    long_press = 1; step(); long_press = 0;
    chk("R2 press exits", mode_code, 1);
    step();
    chk("R6 charge after ship", mode_code, 5);
    chk("R11 code", mode_code, 5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule